// File: doc/BRIEF.md
# Audio Serial Data Transmitter

This block turns a stream of audio sample words into a one-bit serial data line for a stereo or time-division-multiplexed audio link. It does not make its own bit clock. An external frame generator gives a one-cycle bit strobe for each bit-clock period, a slot-start marker on the first bit period of every slot, and a flag that marks the slot as the right channel (or an odd channel). The transmitter takes a sample word over a valid/ready handshake at the start of each slot that needs one. It aligns the sample to its most significant bit and shifts it out MSB first. Any bit periods left in the slot after the sample are driven low.

The data-length code selects plain words, where the sample sits in the low bits of the word, or packed stereo words, where one word holds both the left and the right sample. In mono mode, the left sample is sent again in the right slot. When a slot starts and no word is waiting, the block raises a one-cycle underrun flag. It then sends either silence or a repeat of the last sample sent on the same side, depending on a configuration bit. The format code sets where the MSB falls: one bit period after the slot boundary, or on the boundary itself.

Top module: `aud_serial_tx`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `sdo` and `underrun` are 0. `s_ready` is 0 whenever `bit_tick` is low.
- R2: `sdo` is registered and changes only in the cycle after a cycle with `bit_tick` high. Samples are shifted out MSB first, one bit per `bit_tick`.
- R3: Format codes 1 and 3 put the MSB in the first bit period of the slot (the tick carrying `slot_start`). Codes 0 and 2 put it in the second bit period, and the first bit period carries the bit that follows on from the previous slot's shift.
- R4: Length codes 0, 1, 2, 3, 4 and 6 send the low 32, 24, 20, 18, 16 and 8 bits of the word. Every bit period after the sample's LSB drives 0.
- R5: Length code 5 is packed 16-bit stereo. The word taken in a left slot (`slot_right`=0) supplies bits 15:0 there. Bits 31:16 of the same word are sent in the following right slot, and no new word is taken in that right slot.
- R6: Length code 7 is packed 8-bit stereo. Bits 7:0 of the left-slot word go to the left slot and bits 15:8 go to the right slot, from the same single word.
- R7: With `cfg_mono`=1, every right slot repeats the left sample of the most recent left-slot word, and no word is taken in a right slot.
- R8: `s_ready` is high, combinationally, exactly in cycles with `bit_tick` and `slot_start` high where the slot needs a word. A left slot always needs a word. A right slot needs one only when neither mono nor a packed length is selected.
- R9: `underrun` is high for exactly one cycle: the cycle after a slot start in which `s_ready` was high and `s_valid` was low.
- R10: On underrun, the slot carries all zeros if `cfg_hold`=0. If `cfg_hold`=1, it carries the last sample sent on the same side. With `cfg_hold`=0 in packed or mono modes, the following right slot is zero as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_format | input | 2 | Format code: 0/2 delayed MSB, 1/3 MSB on slot edge |
| cfg_len | input | 3 | Data-length code (see R4 to R6) |
| cfg_mono | input | 1 | Send left sample again in right slots |
| cfg_hold | input | 1 | Underrun policy: 0 zeros, 1 repeat last sample |
| bit_tick | input | 1 | One-cycle strobe per bit-clock period |
| slot_start | input | 1 | Marks the first bit period of a slot (with bit_tick) |
| slot_right | input | 1 | Current slot is a right/odd slot |
| s_valid | input | 1 | Sample word available |
| s_data | input | 32 | Sample word |
| s_ready | output | 1 | Word taken this cycle when s_valid is high |
| sdo | output | 1 | Serial data out |
| underrun | output | 1 | One-cycle pulse on a starved slot start |

## Verification
The bench uses the default 32-bit word. That size makes all eight length codes legal, so every plain and packed layout is driven with random data. Slot lengths of 32, 33, 34 and 36 bit periods are used. Slots longer than the sample bring the zero tail into reach, and 32-bit slots with the delayed formats carry the previous LSB into the next slot's first bit period. Gaps of one to three clocks between bit strobes check that the output holds between ticks. Valid rates of 40 to 60 percent in some phases drive both underrun policies together with mono and packed modes.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

  localparam int TX_WORD_W = 32;
  localparam int LEN_W     = $clog2(TX_WORD_W) + 1;

  typedef enum logic [1:0] {
    FMT_DELAY    = 2'd0,
    FMT_EDGE     = 2'd1,
    FMT_TDM      = 2'd2,
    FMT_TDM_EDGE = 2'd3
  } fmt_e;

  typedef enum logic [2:0] {
    LEN_W32  = 3'd0,
    LEN_W24  = 3'd1,
    LEN_W20  = 3'd2,
    LEN_W18  = 3'd3,
    LEN_W16  = 3'd4,
    LEN_P16  = 3'd5,
    LEN_W8   = 3'd6,
    LEN_P8   = 3'd7
  } len_e;

  typedef struct packed {
    logic             msb_on_edge;
    logic             packed_pair;
    logic [LEN_W-1:0] width;
  } lane_cfg_t;

endpackage

// File: rtl/aud_tx_cfg_decode.sv
module aud_tx_cfg_decode
  import aud_tx_pkg::*;
#(
  parameter int WORD_W = TX_WORD_W
) (
  input  logic [1:0] cfg_format,
  input  logic [2:0] cfg_len,
  output lane_cfg_t  lane
);
  localparam int HALF_W = WORD_W / 2;
  localparam int QTR_W  = WORD_W / 4;

  always_comb begin
    lane             = '0;
    lane.msb_on_edge = (fmt_e'(cfg_format) == FMT_EDGE) ||
                       (fmt_e'(cfg_format) == FMT_TDM_EDGE);
    case (len_e'(cfg_len))
      LEN_W32: begin lane.width = LEN_W'(WORD_W); lane.packed_pair = 1'b0; end
      LEN_W24: begin lane.width = LEN_W'(24);     lane.packed_pair = 1'b0; end
      LEN_W20: begin lane.width = LEN_W'(20);     lane.packed_pair = 1'b0; end
      LEN_W18: begin lane.width = LEN_W'(18);     lane.packed_pair = 1'b0; end
      LEN_W16: begin lane.width = LEN_W'(HALF_W); lane.packed_pair = 1'b0; end
      LEN_P16: begin lane.width = LEN_W'(HALF_W); lane.packed_pair = 1'b1; end
      LEN_W8:  begin lane.width = LEN_W'(QTR_W);  lane.packed_pair = 1'b0; end
      default: begin lane.width = LEN_W'(QTR_W);  lane.packed_pair = 1'b1; end
    endcase
  end
endmodule

// File: rtl/aud_tx_sample_sel.sv
module aud_tx_sample_sel
  import aud_tx_pkg::*;
#(
  parameter int WORD_W = TX_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  lane_cfg_t         lane,
  input  logic              cfg_mono,
  input  logic              cfg_hold,
  input  logic              strobe,
  input  logic              slot_right,
  input  logic              s_valid,
  input  logic [WORD_W-1:0] s_data,
  output logic              s_ready,
  output logic [WORD_W-1:0] aligned,
  output logic              underrun
);
  logic              shared_right;
  logic              take;
  logic              starve;
  logic [LEN_W-1:0]  sh;
  logic [WORD_W-1:0] pair_q;
  logic [WORD_W-1:0] last_l_q;
  logic [WORD_W-1:0] last_r_q;

  // right slot served from the stored word (mono copy or upper packed half)
  assign shared_right = slot_right && (cfg_mono || lane.packed_pair);
  assign s_ready      = strobe && !shared_right;
  assign take         = s_ready && s_valid;
  assign starve       = s_ready && !s_valid;
  assign sh           = LEN_W'(WORD_W) - lane.width;

  always_comb begin
    if (shared_right) begin
      if (cfg_mono) aligned = pair_q << sh;
      else          aligned = (pair_q >> lane.width) << sh;
    end else if (take) begin
      aligned = s_data << sh;
    end else if (cfg_hold) begin
      aligned = slot_right ? last_r_q : last_l_q;
    end else begin
      aligned = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_q   <= '0;
      last_l_q <= '0;
      last_r_q <= '0;
      underrun <= 1'b0;
    end else begin
      underrun <= starve;
      if (strobe) begin
        if (slot_right) last_r_q <= aligned;
        else            last_l_q <= aligned;
        if (!slot_right) begin
          if (take)           pair_q <= s_data;
          else if (!cfg_hold) pair_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/aud_tx_shifter.sv
module aud_tx_shifter #(
  parameter int WORD_W = aud_tx_pkg::TX_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              load,
  input  logic              msb_on_edge,
  input  logic [WORD_W-1:0] aligned,
  output logic              sdo
);
  logic [WORD_W-1:0] shreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      sdo     <= 1'b0;
    end else if (bit_tick) begin
      if (load && msb_on_edge) begin
        sdo     <= aligned[WORD_W-1];
        shreg_q <= {aligned[WORD_W-2:0], 1'b0};
      end else if (load) begin
        sdo     <= shreg_q[WORD_W-1];
        shreg_q <= aligned;
      end else begin
        sdo     <= shreg_q[WORD_W-1];
        shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/aud_serial_tx.sv
module aud_serial_tx
  import aud_tx_pkg::*;
#(
  parameter int WORD_W = TX_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_format,
  input  logic [2:0]        cfg_len,
  input  logic              cfg_mono,
  input  logic              cfg_hold,
  input  logic              bit_tick,
  input  logic              slot_start,
  input  logic              slot_right,
  input  logic              s_valid,
  input  logic [WORD_W-1:0] s_data,
  output logic              s_ready,
  output logic              sdo,
  output logic              underrun
);
  lane_cfg_t         lane;
  logic              strobe;
  logic [WORD_W-1:0] aligned;

  assign strobe = bit_tick && slot_start;

  aud_tx_cfg_decode #(.WORD_W(WORD_W)) u_dec (
    .cfg_format (cfg_format),
    .cfg_len    (cfg_len),
    .lane       (lane)
  );

  aud_tx_sample_sel #(.WORD_W(WORD_W)) u_sel (
    .clk        (clk),
    .rst        (rst),
    .lane       (lane),
    .cfg_mono   (cfg_mono),
    .cfg_hold   (cfg_hold),
    .strobe     (strobe),
    .slot_right (slot_right),
    .s_valid    (s_valid),
    .s_data     (s_data),
    .s_ready    (s_ready),
    .aligned    (aligned),
    .underrun   (underrun)
  );

  aud_tx_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .bit_tick    (bit_tick),
    .load        (strobe),
    .msb_on_edge (lane.msb_on_edge),
    .aligned     (aligned),
    .sdo         (sdo)
  );
endmodule

// File: rtl/aud_serial_tx_chk.sv
module aud_serial_tx_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cfg_format,
  input logic [2:0]        cfg_len,
  input logic              bit_tick,
  input logic              slot_start,
  input logic              slot_right,
  input logic              s_valid,
  input logic [WORD_W-1:0] s_data,
  input logic              s_ready,
  input logic              sdo,
  input logic              underrun
);
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sdo && !underrun));

  p_ready_needs_tick_r1: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |-> !s_ready);

  p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_tick) |-> $stable(sdo));

  p_ready_only_at_start_r8: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> (bit_tick && slot_start));

  p_left_always_ready_r8: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && slot_start && !slot_right) |-> s_ready);

  p_starve_flags_r9: assert property (@(posedge clk) disable iff (rst)
    (s_ready && !s_valid) |=> underrun);

  p_flag_has_cause_r9: assert property (@(posedge clk) disable iff (rst)
    underrun |-> $past(s_ready && !s_valid));

  p_edge_msb_r3: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && slot_start && cfg_format[0] && s_ready && s_valid && cfg_len == 3'd0)
      |=> (sdo == $past(s_data[WORD_W-1])));
endmodule

bind aud_serial_tx aud_serial_tx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_format (cfg_format),
  .cfg_len    (cfg_len),
  .bit_tick   (bit_tick),
  .slot_start (slot_start),
  .slot_right (slot_right),
  .s_valid    (s_valid),
  .s_data     (s_data),
  .s_ready    (s_ready),
  .sdo        (sdo),
  .underrun   (underrun)
);

// File: tb/aud_serial_tx_tb.sv
`timescale 1ns/1ps
module aud_serial_tx_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_format = '0;
  logic [2:0]  cfg_len = '0;
  logic        cfg_mono = 1'b0;
  logic        cfg_hold = 1'b0;
  logic        bit_tick = 1'b0;
  logic        slot_start = 1'b0;
  logic        slot_right = 1'b0;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_ready;
  logic        sdo;
  logic        underrun;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [31:0] m_pair, m_last_l, m_last_r, m_cur, m_prev;
  logic        exp_sdo, exp_und;
  string       sdo_tag;

  always #2.5 clk = ~clk;

  aud_serial_tx u_dut (
    .clk(clk), .rst(rst), .cfg_format(cfg_format), .cfg_len(cfg_len),
    .cfg_mono(cfg_mono), .cfg_hold(cfg_hold), .bit_tick(bit_tick),
    .slot_start(slot_start), .slot_right(slot_right), .s_valid(s_valid),
    .s_data(s_data), .s_ready(s_ready), .sdo(sdo), .underrun(underrun)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int width_of(input logic [2:0] code);
    case (code)
      3'd0: return 32;
      3'd1: return 24;
      3'd2: return 20;
      3'd3: return 18;
      3'd4, 3'd5: return 16;
      default: return 8;
    endcase
  endfunction

  function automatic bit is_packed(input logic [2:0] code);
    return (code == 3'd5) || (code == 3'd7);
  endfunction

  function automatic logic bit_at(input logic [31:0] a, input int idx);
    if (idx >= 0 && idx < 32) return a[idx];
    return 1'b0;
  endfunction

  // sample (low width bits) moved to the top of the word
  function automatic logic [31:0] top_align(input logic [31:0] w, input int wd);
    logic [31:0] m;
    m = (wd == 32) ? 32'hFFFF_FFFF : ((32'd1 << wd) - 32'd1);
    return (w & m) << (32 - wd);
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    bit_tick = 0; slot_start = 0; s_valid = 0; slot_right = 0;
    repeat (3) @(negedge clk);
    chk(sdo === 1'b0, "R1", "sdo in reset", 32'(sdo), 0);
    chk(underrun === 1'b0, "R1", "underrun in reset", 32'(underrun), 0);
    chk(s_ready === 1'b0, "R1", "s_ready idle", 32'(s_ready), 0);
    rst = 1'b0;
    m_pair = '0; m_last_l = '0; m_last_r = '0; m_cur = '0; m_prev = '0;
    exp_sdo = 1'b0; exp_und = 1'b0;
  endtask

  task automatic run_phase(input logic [1:0] fmt, input logic [2:0] len,
                           input bit mono, input bit hold, input int nslots,
                           input int slen, input int gap, input int vprob);
    int wd;
    bit lj;
    wd = width_of(len);
    lj = fmt[0];
    cfg_format = fmt; cfg_len = len; cfg_mono = mono; cfg_hold = hold;
    do_reset();
    for (int s = 0; s < nslots; s++) begin
      bit right, shared, need, val, starve;
      logic [31:0] word, al;
      right  = s[0];
      shared = right && (mono || is_packed(len));
      need   = !shared;
      val    = ($urandom % 100) < vprob;
      word   = $urandom;
      starve = need && !val;
      if (shared)
        al = mono ? top_align(m_pair, wd) : top_align(m_pair >> wd, wd);
      else if (val)
        al = top_align(word, wd);
      else if (hold)
        al = right ? m_last_r : m_last_l;
      else
        al = '0;
      if (starve)                     sdo_tag = "R10";
      else if (mono && right)         sdo_tag = "R7";
      else if (len == 3'd5)           sdo_tag = "R5";
      else if (len == 3'd7)           sdo_tag = "R6";
      else                            sdo_tag = "R4";
      for (int k = 0; k < slen; k++) begin
        for (int g = 0; g < gap; g++) begin
          bit tick, first;
          @(negedge clk);
          chk(sdo === exp_sdo, (k == 1 && g == 0) ? "R3" : sdo_tag,
              "sdo bit", 32'(sdo), 32'(exp_sdo));
          chk(underrun === exp_und, "R9", "underrun pulse", 32'(underrun), 32'(exp_und));
          tick  = (g == gap - 1);
          first = tick && (k == 0);
          bit_tick   = tick;
          slot_start = first;
          slot_right = right;
          s_valid    = first ? val : ($urandom % 2);
          s_data     = first ? word : $urandom;
          #1;
          chk(s_ready === (first && need), first ? "R8" : "R2",
              "s_ready", 32'(s_ready), 32'(first && need));
          exp_und = first && starve;
          if (first) begin
            m_prev = m_cur;
            m_cur  = al;
            if (right) m_last_r = al;
            else begin
              m_last_l = al;
              if (val)        m_pair = word;
              else if (!hold) m_pair = '0;
            end
          end
          if (tick) begin
            if (lj)          exp_sdo = bit_at(m_cur, 31 - k);
            else if (k == 0) exp_sdo = bit_at(m_prev, 32 - slen);
            else             exp_sdo = bit_at(m_cur, 32 - k);
          end
        end
      end
    end
    @(negedge clk);
    chk(sdo === exp_sdo, "R2", "final sdo", 32'(sdo), 32'(exp_sdo));
    chk(underrun === exp_und, "R9", "final underrun", 32'(underrun), 32'(exp_und));
    bit_tick = 0; slot_start = 0; s_valid = 0;
    @(negedge clk);
    chk(sdo === exp_sdo, "R2", "sdo holds without tick", 32'(sdo), 32'(exp_sdo));
  endtask

  initial begin
    void'($urandom(32'h5EED_0A11));
    // directed corners
    run_phase(2'd0, 3'd0, 0, 0, 6, 32, 1, 100); // R3 delayed, LSB carried over
    run_phase(2'd1, 3'd0, 0, 0, 6, 32, 1, 100); // R3 on edge, R4 full word
    run_phase(2'd1, 3'd4, 0, 0, 6, 34, 2, 100); // R4 zero tail, R2 gaps
    run_phase(2'd3, 3'd5, 0, 0, 8, 32, 1, 100); // R5 packed 16
    run_phase(2'd2, 3'd7, 0, 0, 8, 34, 1, 100); // R6 packed 8
    run_phase(2'd0, 3'd1, 1, 0, 8, 32, 1, 100); // R7 mono
    run_phase(2'd1, 3'd2, 0, 0, 10, 33, 1, 40); // R10 zeros
    run_phase(2'd0, 3'd3, 0, 1, 10, 32, 1, 40); // R10 repeat
    run_phase(2'd3, 3'd6, 1, 1, 10, 32, 2, 40); // R7 with R10 repeat
    run_phase(2'd1, 3'd5, 0, 1, 10, 32, 1, 40); // R5 with R10 repeat
    run_phase(2'd2, 3'd7, 0, 0, 10, 36, 1, 40); // R6 with R10 zeros
    // random mix
    for (int p = 0; p < 16; p++) begin
      int sl;
      case ($urandom % 3)
        0: sl = 32;
        1: sl = 33;
        default: sl = 36;
      endcase
      run_phase(2'($urandom), 3'($urandom), 1'($urandom), 1'($urandom),
                12, sl, 1 + ($urandom % 3), 60);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule